// File: doc/BRIEF.md
# Keypad Combination Lock Sequencer

This block watches a 3-column by 4-row matrix keypad and opens a lock only after a stored four-digit code has been keyed in order. A key counts as one digit only once it has been pressed and then let go, so that the keypad reads all-released again. A key that is not the expected one, or a pattern that is not a single clean key, sends the sequencer back to its idle state. The keypad lines are taken as already scanned and debounced, and the code is fixed by a parameter.

Once the last digit has been released, the lock output goes high. The sequencer then walks through a run of open states, one per clock, whatever the keypad shows. When that run ends, it falls back to idle with the lock closed and ready for a new attempt. The state number is always visible on a debug output. The intended clock is a few hertz, so the open time is some seconds long.

Top module: `keypad_seq_lock`

## Requirements
- R1: A synchronous active-high reset forces state 0 with `unlock_o` low, from any state, including the open states.
- R2: Key encoding: `col_i[0]`, `col_i[1]` and `col_i[2]` are the left, middle and right columns, and `row_i[0]` to `row_i[3]` are the top to bottom rows. Digit d in 1..9 is column (d-1)%3 and row (d-1)/3. Digit 0 is the middle column of the bottom row. A key is exactly one column bit and one row bit set. All zero on both vectors means released.
- R3: In state 0 (idle), the first code digit moves the state to 1. Any other key or the released pattern leaves it at 0.
- R4: While the expected key is held in a pressed state (odd state 2i+1 for digit i), the state does not change.
- R5: The released pattern moves a pressed state 2i+1 to 2i+2. In a waiting state 2i (i>0), the released pattern keeps the state, and the next code digit moves it to 2i+1.
- R6: A valid key that is not the expected digit, in any state below 8, returns the state to 0 on the next clock. This includes pressing a new key without releasing the previous one.
- R7: A pattern that is neither released nor a single clean key, such as two columns, two rows, or a column without a row, counts as a wrong key and returns any entry state to 0.
- R8: Releasing the fourth digit enters state 8. From state 8 the state advances by one per clock up to 31 and then returns to 0.
- R9: `unlock_o` is high for exactly 24 consecutive clocks, in states 8 to 31. After that the lock has re-armed, and a full correct code opens it again.
- R10: `unlock_o` is low in state 0 and in states 1 to 7. `state_o` shows the state number in binary.
- R11: Keypad input during the open states has no effect on the state sequence or on `unlock_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| col_i | input | 3 | Keypad column lines, one bit per column |
| row_i | input | 4 | Keypad row lines, one bit per row |
| unlock_o | output | 1 | Lock release, registered |
| state_o | output | 5 | Current state number, registered |

## Verification
Every keypad pattern is acted on at the next rising edge, and both outputs are registers. A wrong next-state decision therefore shows on `state_o` one clock after the offending input: a stuck or skipped entry state, a missed fall back to idle, or an open run that is too short or too long. A mismatch between the lock output and the state range shows in that same sample. The open window is measured cycle by cycle on `unlock_o`, with keys pressed during it. Every digit is also tried from idle to confirm the key-to-digit mapping.

// File: rtl/kp_lock_pkg.sv
`timescale 1ns/1ps
package kp_lock_pkg;
  parameter int KP_COLS = 3;
  parameter int KP_ROWS = 4;
  parameter int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] NO_DIGIT = '1;

  typedef struct packed {
    logic               released;
    logic               valid;
    logic [DIGIT_W-1:0] digit;
  } key_t;
endpackage

// File: rtl/kp_key_decode.sv
`timescale 1ns/1ps
module kp_key_decode
  import kp_lock_pkg::*;
#(
  parameter int COLS = KP_COLS,
  parameter int ROWS = KP_ROWS
) (
  input  logic [COLS-1:0] col_i,
  input  logic [ROWS-1:0] row_i,
  output key_t            key_o
);
  localparam int CI_W     = $clog2(COLS);
  localparam int RI_W     = $clog2(ROWS);
  localparam int ZERO_COL = COLS / 2;

  logic [CI_W-1:0] col_idx;
  logic [RI_W-1:0] row_idx;

  always_comb begin
    col_idx = '0;
    row_idx = '0;
    for (int i = 0; i < COLS; i++)
      if (col_i[i]) col_idx = CI_W'(i);
    for (int j = 0; j < ROWS; j++)
      if (row_i[j]) row_idx = RI_W'(j);
  end

  always_comb begin
    key_o.released = (col_i == '0) && (row_i == '0);
    key_o.valid    = $onehot(col_i) && $onehot(row_i);
    if (int'(row_idx) < ROWS - 1)
      key_o.digit = DIGIT_W'(int'(row_idx) * COLS + int'(col_idx) + 1);
    else if (int'(col_idx) == ZERO_COL)
      key_o.digit = '0;
    else
      key_o.digit = NO_DIGIT;
  end
endmodule

// File: rtl/kp_seq_next.sv
`timescale 1ns/1ps
module kp_seq_next
  import kp_lock_pkg::*;
#(
  parameter int                       DIGITS  = 4,
  parameter int                       STATE_W = 5,
  parameter logic [DIGIT_W*DIGITS-1:0] CODE   = 16'h4702
) (
  input  logic [STATE_W-1:0] state_i,
  input  key_t               key_i,
  output logic [STATE_W-1:0] next_o
);
  localparam int                 IDX_W     = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [STATE_W-1:0] OPEN_BASE = STATE_W'(2 * DIGITS);
  localparam logic [STATE_W-1:0] LAST      = '1;

  logic [DIGIT_W-1:0] exp_digit [DIGITS];

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_code
      assign exp_digit[g] = CODE[DIGIT_W*(DIGITS-1-g) +: DIGIT_W];
    end
  endgenerate

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             pressed_state;
  logic             in_open;

  assign idx           = state_i[IDX_W:1];
  assign in_open       = (state_i >= OPEN_BASE);
  assign pressed_state = state_i[0];
  assign hit           = key_i.valid && !in_open && (key_i.digit == exp_digit[idx]);

  always_comb begin
    next_o = '0;
    if (in_open) begin
      next_o = (state_i == LAST) ? '0 : state_i + 1'b1;
    end else if (pressed_state) begin
      if (key_i.released)  next_o = state_i + 1'b1;
      else if (hit)        next_o = state_i;
      else                 next_o = '0;
    end else begin
      if (hit)                  next_o = state_i + 1'b1;
      else if (key_i.released)  next_o = state_i;
      else                      next_o = '0;
    end
  end
endmodule

// File: rtl/kp_state_reg.sv
`timescale 1ns/1ps
module kp_state_reg #(
  parameter int STATE_W = 5,
  parameter int DIGITS  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] next_i,
  output logic [STATE_W-1:0] state_o,
  output logic               unlock_o
);
  localparam logic [STATE_W-1:0] OPEN_BASE = STATE_W'(2 * DIGITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o  <= '0;
      unlock_o <= 1'b0;
    end else begin
      state_o  <= next_i;
      unlock_o <= (next_i >= OPEN_BASE);
    end
  end
endmodule

// File: rtl/keypad_seq_lock.sv
`timescale 1ns/1ps
module keypad_seq_lock
  import kp_lock_pkg::*;
#(
  parameter int                        DIGITS  = 4,
  parameter int                        STATE_W = 5,
  parameter logic [DIGIT_W*DIGITS-1:0] CODE    = 16'h4702
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [KP_COLS-1:0] col_i,
  input  logic [KP_ROWS-1:0] row_i,
  output logic               unlock_o,
  output logic [STATE_W-1:0] state_o
);
  initial begin
    if (2 * DIGITS >= (1 << STATE_W) - 1)
      $error("state space too small for code length");
  end

  key_t               key;
  logic [STATE_W-1:0] next_state;

  kp_key_decode #(.COLS(KP_COLS), .ROWS(KP_ROWS)) u_decode (
    .col_i (col_i),
    .row_i (row_i),
    .key_o (key)
  );

  kp_seq_next #(.DIGITS(DIGITS), .STATE_W(STATE_W), .CODE(CODE)) u_next (
    .state_i (state_o),
    .key_i   (key),
    .next_o  (next_state)
  );

  kp_state_reg #(.STATE_W(STATE_W), .DIGITS(DIGITS)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .next_i   (next_state),
    .state_o  (state_o),
    .unlock_o (unlock_o)
  );
endmodule

// File: rtl/keypad_seq_lock_chk.sv
`timescale 1ns/1ps
module keypad_seq_lock_chk #(
  parameter int DIGITS  = 4,
  parameter int STATE_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         col_i,
  input logic [3:0]         row_i,
  input logic               unlock_o,
  input logic [STATE_W-1:0] state_o
);
  localparam logic [STATE_W-1:0] OPEN_BASE = STATE_W'(2 * DIGITS);
  localparam logic [STATE_W-1:0] LAST      = '1;

  logic idle_in;
  logic junk_in;
  assign idle_in = (col_i == 3'b000) && (row_i == 4'b0000);
  assign junk_in = !idle_in && (($countones(col_i) != 1) || ($countones(row_i) != 1));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (state_o == '0) && !unlock_o);

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state_o == '0) && idle_in |=> state_o == '0);

  a_r5_release_advances: assert property (@(posedge clk) disable iff (rst)
    (state_o < OPEN_BASE) && state_o[0] && idle_in |=> state_o == $past(state_o) + 1'b1);

  a_r7_junk_to_idle: assert property (@(posedge clk) disable iff (rst)
    (state_o < OPEN_BASE) && junk_in |=> state_o == '0);

  a_r8_open_steps: assert property (@(posedge clk) disable iff (rst)
    (state_o >= OPEN_BASE) && (state_o != LAST) |=> state_o == $past(state_o) + 1'b1);

  a_r9_open_ends: assert property (@(posedge clk) disable iff (rst)
    (state_o == LAST) |=> (state_o == '0) && !unlock_o);

  a_r10_unlock_range: assert property (@(posedge clk) disable iff (rst)
    unlock_o == (state_o >= OPEN_BASE));
endmodule

bind keypad_seq_lock keypad_seq_lock_chk #(.DIGITS(DIGITS), .STATE_W(STATE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .col_i    (col_i),
  .row_i    (row_i),
  .unlock_o (unlock_o),
  .state_o  (state_o)
);

// File: tb/test_keypad_seq_lock.sv
`timescale 1ns/1ps
module test_keypad_seq_lock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] col = '0;
  logic [3:0] row = '0;
  logic       unlock;
  logic [4:0] state;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  int code [4] = '{4, 7, 0, 2};

  always #2.5 clk = ~clk;

  keypad_seq_lock #(.DIGITS(4), .STATE_W(5), .CODE(16'h4702)) i_keypad_seq_lock (
    .clk      (clk),
    .rst      (rst),
    .col_i    (col),
    .row_i    (row),
    .unlock_o (unlock),
    .state_o  (state)
  );

  // R2 key mapping
  function automatic logic [2:0] kcol(int d);
    if (d == 0) return 3'b010;
    return 3'(1 << ((d - 1) % 3));
  endfunction
  function automatic logic [3:0] krow(int d);
    if (d == 0) return 4'b1000;
    return 4'(1 << ((d - 1) / 3));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(logic [2:0] c, logic [3:0] r);
    col = c;
    row = r;
    @(negedge clk);
  endtask

  task automatic key(int d);
    step(kcol(d), krow(d));
  endtask

  task automatic rel();
    step(3'b000, 4'b0000);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3'b000, 4'b0000);
    step(3'b000, 4'b0000);
    rst = 1'b0;
  endtask

  task automatic enter_code();
    for (int i = 0; i < 4; i++) begin
      key(code[i]);
      check("R4 pressed state", state, 2 * i + 1);
      rel();
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset state", state, 0);
    check("R1 reset unlock", unlock, 0);
  endtask

  task automatic t_digit_map();
    for (int d = 0; d < 10; d++) begin
      do_reset();
      key(d);
      check($sformatf("R2 R3 digit %0d from idle", d), state, (d == code[0]) ? 1 : 0);
    end
    do_reset();
    step(3'b100, 4'b1000);
    check("R2 non-digit key ignored in idle", state, 0);
    rel();
    check("R3 idle holds on release", state, 0);
  endtask

  task automatic t_correct_code();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      key(code[i]);
      check("R5 next digit enters pressed", state, 2 * i + 1);
      check("R10 unlock low during entry", unlock, 0);
      key(code[i]);
      key(code[i]);
      check("R4 held key keeps state", state, 2 * i + 1);
      rel();
      check("R5 release advances", state, 2 * i + 2);
      if (i < 3) begin
        rel();
        rel();
        check("R5 waiting holds on release", state, 2 * i + 2);
        check("R10 unlock low while waiting", unlock, 0);
      end
    end
    check("R8 open state entered", state, 8);
    check("R9 unlock high on open", unlock, 1);
  endtask

  task automatic t_open_window();
    int cnt;
    int prev;
    int bad;
    cnt  = 1;
    prev = state;
    bad  = 0;
    while (unlock && cnt < 100) begin
      step(kcol(code[cnt % 4]), krow(code[cnt % 4]));
      if (unlock) begin
        cnt++;
        if (state != prev + 1) bad++;
        prev = state;
      end
    end
    check("R8 R11 open states step by one under key input", bad, 0);
    check("R9 open length", cnt, 24);
    check("R9 back to idle after open", state, 0);
    check("R9 unlock low after open", unlock, 0);
  endtask

  task automatic t_wrong_digit();
    do_reset();
    key(code[0]); rel();
    key(code[1]); rel();
    key(5);
    check("R6 wrong digit in waiting state", state, 0);
    do_reset();
    key(code[0]); rel();
    key(code[1]);
    key(code[2]);
    check("R6 new key without release", state, 0);
    do_reset();
    key(code[0]);
    key(9);
    check("R6 wrong key in pressed state", state, 0);
  endtask

  task automatic t_junk();
    do_reset();
    key(code[0]); rel();
    step(kcol(code[1]) | 3'b010, krow(code[1]));
    check("R7 two columns", state, 0);
    do_reset();
    key(code[0]);
    step(kcol(code[0]), krow(code[0]) | 4'b0100);
    check("R7 two rows while pressed", state, 0);
    do_reset();
    key(code[0]); rel();
    step(3'b001, 4'b0000);
    check("R7 column without row", state, 0);
  endtask

  task automatic t_rearm();
    enter_code();
    check("R9 re-armed lock opens again", unlock, 1);
    check("R8 re-armed state", state, 8);
    rst = 1'b1;
    rel();
    rst = 1'b0;
    check("R1 reset from open state", state, 0);
    check("R1 reset closes lock", unlock, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_digit_map();
    t_correct_code();
    t_open_window();
    t_wrong_digit();
    t_junk();
    do_reset();
    t_rearm();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule